// File: doc/BRIEF.md
# Brown-out Lockout and Boot Sequencer

This block supervises supply health for a small 8-bit controller core. A digital under-voltage indication from an analog comparator is brought into the clock domain and, once it is seen, the block puts the chip into a lockout state. In lockout every pin is made an input, a static per-pin pull-up option is applied, and the wake path that would normally release the core from stop mode is shut. Nothing but the external reset leaves lockout. The block never clears data memory on entry to or exit from lockout. Any clearing is left to software.

After reset is released, the block holds all bus activity for a fixed oscillator settling interval. It then reads a two-byte start vector over a simple read port with one cycle of latency, low byte first and high byte second. It presents the assembled 16-bit address to the core and raises the run indication, so the core can begin its first opcode fetch there.

Top module: `brownout_seq`

## Requirements
- R1: The raw under-voltage input passes through SYNC_STAGES (default 2) flops. When it is high before a clock edge and stays high, lockout is in effect (visible at the outputs) after the third rising edge. This holds from the settling wait, from either vector read and from run.
- R2: `wake_ok` is the registered value of `wake_req` only while the core runs. It is 0 in lockout, during reset, during the settling wait and during the vector reads.
- R3: `port_dir` (1 = output, 0 = input) follows `sw_dir` with one register stage while running. In every other state it is all zeros, and this includes lockout whatever `sw_dir` holds.
- R4: In lockout `port_pu` equals the PU_MASK option, which by default has every bit set. Outside lockout `port_pu` is all zeros.
- R5: Once in lockout, the block stays there when the under-voltage input returns low, when `wake_req` pulses and when `sw_dir` changes.
- R6: `rst` is synchronous and active high. While it is sampled high, every output is 0 and any lockout is left.
- R7: After reset, `rd_en` first goes high after the STAB_CYC-th rising edge at which `rst` is low. If `rst` is sampled high again during the wait, the count starts over.
- R8: The vector read drives `rd_en` high with `rd_addr` = 0xFFFE for one cycle. The next cycle carries 0xFFFF, and `rd_en` is low after that. Read data arrives on `rd_data` one cycle after each request.
- R9: Two edges after the 0xFFFF request, `core_run` rises and `start_addr` = {byte read from 0xFFFF, byte read from 0xFFFE}.
- R10: Lockout takes priority over a vector read in progress. The bus goes idle, `core_run` stays low and `start_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high external reset |
| lv_in | input | 1 | Raw under-voltage flag from the comparator |
| wake_req | input | 1 | Stop-mode release request |
| sw_dir | input | N | Software pin direction, 1 = output |
| rd_data | input | 8 | Read data, one cycle after request |
| port_dir | output | N | Effective pin direction |
| port_pu | output | N | Pull-up enables |
| wake_ok | output | 1 | Gated wake request to the core |
| core_run | output | 1 | Core may fetch from start_addr |
| rd_en | output | 1 | Read request strobe |
| rd_addr | output | 16 | Read address |
| start_addr | output | 16 | Assembled start vector |

## Verification
The two functions that can meet in one cycle are lockout entry and the vector read. The bench raises the under-voltage input in the same cycle that the first vector request shows up, so the synchronized flag lands while the high byte is still due. In that cycle the entry into lockout must win. A reference model, advanced on every clock, judges the result: the bus must go idle, `core_run` must never rise and `start_addr` must keep its post-reset value, while the pull-up mask appears in the same cycle.

// File: rtl/bo_pkg.sv
package bo_pkg;
  typedef enum logic [2:0] {
    ST_STAB,
    ST_FLO,
    ST_FHI,
    ST_FEND,
    ST_RUN,
    ST_LOCK
  } bo_state_e;

  localparam logic [15:0] VEC_LO_ADDR = 16'hFFFE;
  localparam logic [15:0] VEC_HI_ADDR = 16'hFFFF;
endpackage

// File: rtl/bo_sync.sv
module bo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/bo_stab_cnt.sv
module bo_stab_cnt #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  assign done = en && (cnt == LAST);
endmodule

// File: rtl/bo_port_ovr.sv
module bo_port_ovr #(
  parameter int           N       = 8,
  parameter logic [N-1:0] PU_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_nx,
  input  logic         lock_nx,
  input  logic [N-1:0] sw_dir,
  output logic [N-1:0] port_dir,
  output logic [N-1:0] port_pu
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        port_dir[i] <= 1'b0;
        port_pu[i]  <= 1'b0;
      end else begin
        port_dir[i] <= run_nx & sw_dir[i];
        port_pu[i]  <= lock_nx & PU_MASK[i];
      end
    end
  end
endmodule

// File: rtl/brownout_seq.sv
module brownout_seq #(
  parameter int           N           = 8,
  parameter int           STAB_CYC    = 1024,
  parameter int           SYNC_STAGES = 2,
  parameter logic [N-1:0] PU_MASK     = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lv_in,
  input  logic         wake_req,
  input  logic [N-1:0] sw_dir,
  input  logic [7:0]   rd_data,
  output logic [N-1:0] port_dir,
  output logic [N-1:0] port_pu,
  output logic         wake_ok,
  output logic         core_run,
  output logic         rd_en,
  output logic [15:0]  rd_addr,
  output logic [15:0]  start_addr
);
  import bo_pkg::*;

  bo_state_e  st, nxt;
  logic       lv_s;
  logic       stab_done;
  logic [7:0] lo_q;
  logic       in_lock;

  bo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (lv_in),
    .q   (lv_s)
  );

  bo_stab_cnt #(.LIMIT(STAB_CYC)) u_stab (
    .clk  (clk),
    .clr  (rst || (st != ST_STAB)),
    .en   (st == ST_STAB),
    .done (stab_done)
  );

  // Lockout entry outranks every sequencing step; reset outranks all.
  always_comb begin
    nxt = st;
    if (lv_s && (st != ST_LOCK)) begin
      nxt = ST_LOCK;
    end else begin
      case (st)
        ST_STAB: if (stab_done) nxt = ST_FLO;
        ST_FLO:  nxt = ST_FHI;
        ST_FHI:  nxt = ST_FEND;
        ST_FEND: nxt = ST_RUN;
        default: nxt = st;
      endcase
    end
    if (rst) nxt = ST_STAB;
  end

  always_ff @(posedge clk) begin
    st       <= nxt;
    rd_en    <= (nxt == ST_FLO) || (nxt == ST_FHI);
    core_run <= (nxt == ST_RUN);
    wake_ok  <= (nxt == ST_RUN) && wake_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr    <= '0;
      start_addr <= '0;
      lo_q       <= '0;
    end else begin
      if (nxt == ST_FLO)      rd_addr <= VEC_LO_ADDR;
      else if (nxt == ST_FHI) rd_addr <= VEC_HI_ADDR;
      if ((st == ST_FHI) && (nxt == ST_FEND)) lo_q <= rd_data;
      if ((st == ST_FEND) && (nxt == ST_RUN)) start_addr <= {rd_data, lo_q};
    end
  end

  bo_port_ovr #(.N(N), .PU_MASK(PU_MASK)) u_ports (
    .clk      (clk),
    .rst      (rst),
    .run_nx   (nxt == ST_RUN),
    .lock_nx  (nxt == ST_LOCK),
    .sw_dir   (sw_dir),
    .port_dir (port_dir),
    .port_pu  (port_pu)
  );

  assign in_lock = (st == ST_LOCK);
endmodule

// File: rtl/bo_chk.sv
module bo_chk #(
  parameter int           N       = 8,
  parameter logic [N-1:0] PU_MASK = '1
) (
  input logic         clk,
  input logic         rst,
  input logic         in_lock,
  input logic [N-1:0] port_dir,
  input logic [N-1:0] port_pu,
  input logic         wake_ok,
  input logic         core_run,
  input logic         rd_en,
  input logic [15:0]  rd_addr
);
  // R3: pins are inputs throughout lockout
  p_lock_dir_r3: assert property (@(posedge clk) disable iff (rst)
    in_lock |-> (port_dir == '0));

  // R4: pull-up option applied in lockout
  p_lock_pu_r4: assert property (@(posedge clk) disable iff (rst)
    in_lock |-> (port_pu == PU_MASK));

  // R2: no wake and no run while locked out
  p_lock_wake_r2: assert property (@(posedge clk) disable iff (rst)
    in_lock |-> (!wake_ok && !core_run && !rd_en));

  // R5: only reset leaves lockout
  p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
    in_lock |=> in_lock);

  // R6: reset clears lockout and run
  p_reset_clear_r6: assert property (@(posedge clk)
    rst |=> (!in_lock && !core_run && !rd_en));

  // R8: high-byte request directly follows the low-byte request
  p_fetch_order_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_addr == 16'hFFFF)) |-> ($past(rd_en) && ($past(rd_addr) == 16'hFFFE)));

  // R9: no bus request while the core runs
  p_run_idle_r9: assert property (@(posedge clk) disable iff (rst)
    core_run |-> !rd_en);
endmodule

bind brownout_seq bo_chk #(.N(N), .PU_MASK(PU_MASK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_lock  (in_lock),
  .port_dir (port_dir),
  .port_pu  (port_pu),
  .wake_ok  (wake_ok),
  .core_run (core_run),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr)
);

// File: tb/test_brownout_seq.sv
module test_brownout_seq;
  localparam int N    = 8;
  localparam int STAB = 20;

  logic         clk = 1'b0;
  logic         rst;
  logic         lv_in;
  logic         wake_req;
  logic [N-1:0] sw_dir;
  logic [7:0]   rd_data;
  logic [N-1:0] port_dir, port_pu;
  logic         wake_ok, core_run, rd_en;
  logic [15:0]  rd_addr, start_addr;

  logic [7:0] vec_lo, vec_hi;
  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  brownout_seq #(.N(N), .STAB_CYC(STAB)) i_brownout_seq (
    .clk(clk), .rst(rst), .lv_in(lv_in), .wake_req(wake_req), .sw_dir(sw_dir),
    .rd_data(rd_data), .port_dir(port_dir), .port_pu(port_pu), .wake_ok(wake_ok),
    .core_run(core_run), .rd_en(rd_en), .rd_addr(rd_addr), .start_addr(start_addr)
  );

  // Vector memory with one cycle of read latency
  always @(posedge clk) begin
    if (rd_en) rd_data <= (rd_addr == 16'hFFFE) ? vec_lo :
                          (rd_addr == 16'hFFFF) ? vec_hi : 8'h00;
  end

  // Behavioural reference: phase 0 wait, 1 low req, 2 high req, 3 assemble, 4 run, 5 locked
  int          m_ph, m_cnt;
  bit          m_p1, m_p2, m_lvd;
  logic [N-1:0] e_dir, e_pu;
  logic        e_wake, e_run, e_rden;
  logic [15:0] e_addr, e_start;
  bit          started = 0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_p1 = 0; m_p2 = 0;
      e_addr = 0; e_start = 0;
    end else begin
      m_lvd = m_p2;
      m_p2  = m_p1;
      m_p1  = lv_in;
      if (m_lvd && m_ph != 5) m_ph = 5;
      else if (m_ph == 0) begin
        m_cnt++;
        if (m_cnt == STAB) m_ph = 1;
      end else if (m_ph == 3) begin
        e_start = {vec_hi, vec_lo};
        m_ph = 4;
      end else if (m_ph == 1 || m_ph == 2) m_ph++;
      if (m_ph == 1) e_addr = 16'hFFFE;
      if (m_ph == 2) e_addr = 16'hFFFF;
    end
    e_run  = (m_ph == 4) && !rst;
    e_dir  = e_run ? sw_dir : '0;
    e_pu   = (m_ph == 5 && !rst) ? {N{1'b1}} : '0;
    e_wake = e_run && wake_req;
    e_rden = (m_ph == 1 || m_ph == 2) && !rst;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check("R3 port_dir model",   32'(port_dir),   32'(e_dir));
      check("R4 port_pu model",    32'(port_pu),    32'(e_pu));
      check("R2 wake_ok model",    32'(wake_ok),    32'(e_wake));
      check("R9 core_run model",   32'(core_run),   32'(e_run));
      check("R8 rd_en model",      32'(rd_en),      32'(e_rden));
      check("R8 rd_addr model",    32'(rd_addr),    32'(e_addr));
      check("R10 start_addr model", 32'(start_addr), 32'(e_start));
    end
  end

  task automatic wait_req(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!rd_en && k < 5000);
  endtask

  initial begin
    int k;
    rst = 1; lv_in = 0; wake_req = 0; sw_dir = '0;
    vec_lo = 8'h34; vec_hi = 8'h12;
    repeat (3) @(negedge clk);
    check("R6 reset core_run", 32'(core_run), 0);
    check("R6 reset rd_en",    32'(rd_en),    0);
    check("R6 reset port_pu",  32'(port_pu),  0);

    rst = 0;
    wait_req(k);
    check("R7 settling length", k, STAB);
    check("R8 first address", 32'(rd_addr), 32'hFFFE);
    @(negedge clk);
    check("R8 second address", 32'(rd_addr), 32'hFFFF);
    @(negedge clk);
    check("R8 bus idle", 32'(rd_en), 0);
    check("R9 not yet running", 32'(core_run), 0);
    @(negedge clk);
    check("R9 running", 32'(core_run), 1);
    check("R9 low byte first", 32'(start_addr), 32'h1234);

    sw_dir = 8'h5A; @(negedge clk);
    check("R3 direction follows", 32'(port_dir), 32'h5A);
    wake_req = 1; @(negedge clk);
    check("R2 wake passes in run", 32'(wake_ok), 1);
    wake_req = 0;

    lv_in = 1;
    repeat (2) @(negedge clk);
    check("R1 still running after two edges", 32'(core_run), 1);
    @(negedge clk);
    check("R1 lockout after third edge", 32'(core_run), 0);
    check("R4 default pull-ups", 32'(port_pu), 32'hFF);
    check("R3 forced inputs", 32'(port_dir), 0);

    lv_in = 0; wake_req = 1; sw_dir = 8'hFF;
    repeat (10) @(negedge clk);
    check("R5 held after flag drops", 32'(port_pu), 32'hFF);
    check("R2 wake ignored", 32'(wake_ok), 0);
    check("R5 dir ignored", 32'(port_dir), 0);
    wake_req = 0;

    vec_lo = 8'hCD; vec_hi = 8'hAB;
    rst = 1; @(negedge clk);
    check("R6 reset leaves lockout", 32'(port_pu), 0);
    rst = 0;
    repeat (STAB / 2) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    wait_req(k);
    check("R7 count restarts", k, STAB);
    repeat (3) @(negedge clk);
    check("R9 second vector", 32'(start_addr), 32'hABCD);

    vec_lo = 8'h11; vec_hi = 8'h22;
    rst = 1; @(negedge clk); rst = 0;
    wait_req(k);
    lv_in = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R10 no run after abort", 32'(core_run), 0);
    end
    check("R10 bus idle", 32'(rd_en), 0);
    check("R10 start kept", 32'(start_addr), 0);
    check("R10 locked", 32'(port_pu), 32'hFF);
    lv_in = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule